// File: doc/BRIEF.md
# Serial to 16-bit parallel panel write bridge

This block converts a host's serial write stream into writes on a 16-bit parallel panel bus. The host drives a mode 0 serial link: a clock, an active-low frame select, one data line and a separate line that marks each word as a command or as data. The bridge shifts in bits, most significant bit first, on rising serial clock edges. Every sixteen bits form one bus word, and the bridge issues that word to the panel with a single write strobe.

Because every bus word is sixteen bits wide, an 8-bit command or setting byte must reach the panel zero-extended. The host therefore sends a 0x00 byte first and the value second. Pixel values are already sixteen bits wide, so they pass through unchanged at two serial bytes per word. If the host releases the frame select partway through a word, the bits gathered so far are thrown away.

All serial lines are brought into the system clock through a synchroniser. The panel side is a valid-only output stream with no ready. The panel must take a word in the cycle its strobe is high. No back-pressure is possible, and none is needed: two strobes are always at least sixteen serial clock periods apart.

Top module: `spi_panel_bridge`

## Requirements
- R1: The first serial bit of a word becomes bit 15 of `wr_word` and the sixteenth becomes bit 0, so the first serial byte lands in bits 15:8 and the second in bits 7:0.
- R2: A host that sends 0x00 followed by an 8-bit value V produces the bus word 0x00V. An all-zero high byte passes through unchanged.
- R3: `wr_dc` takes the level of the command/data line at the rising serial clock edge that captures the word's sixteenth bit: 0 for a command, 1 for parameter or pixel data. The level at the earlier bits has no effect.
- R4: `wr_valid` is high for exactly one system clock per word, one clock after the word is captured. `wr_word` and `wr_dc` hold their value in the clock before, during and after the strobe.
- R5: Raising the frame select before sixteen bits have arrived drops those bits, produces no strobe, and the next word starts from its first bit.
- R6: While the frame select stays low, every further sixteen bits produce one more word with no gap, so a pixel run of N words gives exactly N strobes in order.
- R7: After reset `wr_valid` is 0, `wr_word` is 0x0000 and `wr_dc` is 0.
- R8: Serial clock edges while the frame select is high change no output and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host, idle low |
| cs_n_i | input | 1 | Frame select, active low |
| dc_i | input | 1 | Command (0) or data (1) marker |
| mosi_i | input | 1 | Serial data, most significant bit first |
| wr_valid | output | 1 | One-clock write strobe to the panel |
| wr_word | output | 16 | Bus word |
| wr_dc | output | 1 | Command/data flag of the bus word |

## Verification
The properties assume that the serial lines are slow against the system clock. The serial clock must stay high and low for at least three system clocks each, and the data, marker and frame select lines must hold steady around each rising serial edge. Given that, a word can never complete while the previous strobe is still pending. The stimulus holds each serial clock phase for four system clocks and changes data and marker only while the serial clock is low. It raises the frame select only with the serial clock low, so no rising edge races the frame boundary.

// File: rtl/spb_pkg.sv
package spb_pkg;
  // Positions of the serial lines in the synchronised vector
  localparam int LN_SCK   = 0;
  localparam int LN_CSN   = 1;
  localparam int LN_DC    = 2;
  localparam int LN_MOSI  = 3;
  localparam int LN_COUNT = 4;
  // Idle level of the lines: frame select inactive (high), the rest low
  localparam logic [LN_COUNT-1:0] LN_IDLE = 4'b0010;
endpackage

// File: rtl/spb_sync.sv
module spb_sync #(
  parameter int                WIDTH   = 4,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spb_edge.sv
module spb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/spb_assembler.sv
module spb_assembler #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_i,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              dc_i,
  output logic [WORD_W-1:0] word_o,
  output logic              dc_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q;
  logic              dc_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      dc_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (idle_i) begin
        cnt_q   <= '0;
        shift_q <= '0;
      end else if (bit_en_i) begin
        if (cnt_q == LAST) begin
          word_q <= {shift_q, bit_i};
          dc_q   <= dc_i;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        shift_q <= {shift_q[WORD_W-3:0], bit_i};
      end
    end
  end

  assign word_o = word_q;
  assign dc_o   = dc_q;
  assign done_o = done_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/spi_panel_bridge.sv
module spi_panel_bridge #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              dc_i,
  input  logic              mosi_i,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_word,
  output logic              wr_dc
);
  import spb_pkg::*;

  logic [LN_COUNT-1:0] raw_lines;
  logic [LN_COUNT-1:0] sync_lines;
  logic                sck_rise;
  logic                cs_sync;
  logic                done;
  logic [CNT_W-1:0]    bit_cnt;
  logic                valid_q;

  always_comb begin
    raw_lines          = '0;
    raw_lines[LN_SCK]  = sck_i;
    raw_lines[LN_CSN]  = cs_n_i;
    raw_lines[LN_DC]   = dc_i;
    raw_lines[LN_MOSI] = mosi_i;
  end

  spb_sync #(
    .WIDTH   (LN_COUNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (LN_IDLE)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_lines),
    .sync_o  (sync_lines)
  );

  assign cs_sync = sync_lines[LN_CSN];

  spb_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (sync_lines[LN_SCK]),
    .rise_o  (sck_rise)
  );

  spb_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle_i   (cs_sync),
    .bit_en_i (sck_rise),
    .bit_i    (sync_lines[LN_MOSI]),
    .dc_i     (sync_lines[LN_DC]),
    .word_o   (wr_word),
    .dc_o     (wr_dc),
    .done_o   (done),
    .cnt_o    (bit_cnt)
  );

  // Strobe one clock after capture, so the word is settled a cycle early
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= done;
  end

  assign wr_valid = valid_q;
endmodule

// File: rtl/spb_checks.sv
module spb_checks #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [WORD_W-1:0] wr_word,
  input logic              wr_dc,
  input logic              cs_sync,
  input logic [CNT_W-1:0]  bit_cnt
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R4

  AST_WORD_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($stable(wr_word) && $stable(wr_dc))); // R4

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> ($stable(wr_word) && $stable(wr_dc))); // R4

  AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |=> (bit_cnt == '0)); // R5

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sync && $past(cs_sync)) |=> !wr_valid); // R8
endmodule

bind spi_panel_bridge spb_checks #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/spi_panel_bridge_tb.sv
`timescale 1ns/1ps
module spi_panel_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        dc_i = 1'b0;
  logic        mosi_i = 1'b0;
  logic        wr_valid;
  logic [15:0] wr_word;
  logic        wr_dc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_panel_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_n_i(cs_n_i),
    .dc_i(dc_i), .mosi_i(mosi_i),
    .wr_valid(wr_valid), .wr_word(wr_word), .wr_dc(wr_dc)
  );

  // ---------------- cycle reference model ----------------
  // line history: {mosi, dc, cs_n, sck}, oldest first
  logic [3:0]  hist [$];
  int          m_cnt;
  logic [15:0] m_bits;
  logic [15:0] exp_word;
  logic        exp_dc;
  logic        exp_valid;
  logic        m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {4'b0010, 4'b0010, 4'b0010};
      m_cnt = 0; m_bits = '0; exp_word = '0; exp_dc = 0;
      exp_valid = 0; m_pend = 0;
    end else begin
      logic [3:0] p, s;
      p = hist[0];
      s = hist[1];
      exp_valid = m_pend;
      m_pend = 0;
      if (s[1]) begin
        m_cnt = 0;
      end else if (s[0] && !p[0]) begin
        m_bits = {m_bits[14:0], s[3]};
        m_cnt++;
        if (m_cnt == 16) begin
          exp_word = m_bits;
          exp_dc = s[2];
          m_cnt = 0;
          m_pend = 1;
        end
      end
      hist.push_back({mosi_i, dc_i, cs_n_i, sck_i});
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (wr_valid !== exp_valid) begin
        errors++;
        $display("FAIL R4/R6 cycle strobe: actual %0b expected %0b", wr_valid, exp_valid);
      end else if (wr_word !== exp_word) begin
        errors++;
        $display("FAIL R1 cycle word: actual %h expected %h", wr_word, exp_word);
      end else if (wr_dc !== exp_dc) begin
        errors++;
        $display("FAIL R3 cycle flag: actual %0b expected %0b", wr_dc, exp_dc);
      end
    end
  end

  // ---------------- intent scoreboard ----------------
  logic [16:0] expq [$];
  string       tagq [$];

  always @(negedge clk) begin
    if (rst_n && !finished && wr_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R5/R8 unexpected strobe: actual %h expected none", wr_word);
      end else begin
        logic [16:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({wr_dc, wr_word} !== e) begin
          errors++;
          $display("FAIL %s word: actual %0b/%h expected %0b/%h", t, wr_dc, wr_word, e[16], e[15:0]);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic clk_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(logic b, logic dc);
    sck_i = 1'b0; mosi_i = b; dc_i = dc;
    clk_wait(4);
    sck_i = 1'b1;
    clk_wait(4);
    sck_i = 1'b0;
  endtask

  task automatic frame_start();
    cs_n_i = 1'b0;
    clk_wait(4);
  endtask

  task automatic frame_end();
    sck_i = 1'b0;
    clk_wait(4);
    cs_n_i = 1'b1;
    clk_wait(8);
  endtask

  // dc_last is the marker at the sixteenth bit, dc_early at the others
  task automatic ser_word(logic [15:0] w, logic dc_early, logic dc_last, string tag);
    expq.push_back({dc_last, w});
    tagq.push_back(tag);
    for (int i = 15; i >= 0; i--) ser_bit(w[i], (i == 0) ? dc_last : dc_early);
  endtask

  task automatic ser_partial(logic [15:0] w, int nbits);
    for (int i = 15; i > 15 - nbits; i--) ser_bit(w[i], 1'b1);
  endtask

  task automatic check_drained(string tag);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s missing strobes: actual %0d pending expected 0", tag, expq.size());
    end
  endtask

  initial begin
    clk_wait(5);
    // R7: reset values
    checks++;
    if (wr_valid !== 1'b0 || wr_word !== 16'h0000 || wr_dc !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset: actual %0b/%h/%0b expected 0/0000/0", wr_valid, wr_word, wr_dc);
    end
    @(negedge clk) rst_n = 1'b1;
    clk_wait(4);

    // R2: zero-extended command and parameter
    frame_start(); ser_word(16'h002C, 1'b0, 1'b0, "R2 command"); frame_end();
    frame_start(); ser_word(16'h0055, 1'b1, 1'b1, "R2 parameter"); frame_end();
    check_drained("R2");

    // R1 and R6: pixel run within one frame
    frame_start();
    ser_word(16'hF800, 1'b1, 1'b1, "R1 pixel");
    ser_word(16'h07E0, 1'b1, 1'b1, "R6 pixel");
    ser_word(16'hA5C3, 1'b1, 1'b1, "R6 pixel");
    ser_word(16'h8001, 1'b1, 1'b1, "R1 pixel");
    frame_end();
    check_drained("R6");

    // R5: partial word dropped, next word starts fresh
    frame_start(); ser_partial(16'hFFFF, 5); frame_end();
    frame_start(); ser_word(16'h1234, 1'b0, 1'b0, "R5 after drop"); frame_end();
    frame_start(); ser_partial(16'hFFFF, 15); frame_end();
    frame_start(); ser_word(16'h00B0, 1'b0, 1'b0, "R5 after 15-bit drop"); frame_end();
    check_drained("R5");

    // R8: clocking with frame select high
    for (int k = 0; k < 20; k++) ser_bit(k[0], 1'b1);
    clk_wait(8);
    checks++;
    if (wr_word !== 16'h00B0 || wr_dc !== 1'b0) begin
      errors++;
      $display("FAIL R8 idle clocks: actual %h/%0b expected 00b0/0", wr_word, wr_dc);
    end

    // R3: marker only matters at the last bit
    frame_start();
    ser_word(16'h5A5A, 1'b0, 1'b1, "R3 flip to data");
    ser_word(16'h0029, 1'b1, 1'b0, "R3 flip to command");
    frame_end();
    check_drained("R3");

    clk_wait(10);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule